// File: doc/BRIEF.md
# Polynomial Warp Address Sequencer

This block steps through a programmable rectangle of a target image in raster order. For every target pixel it computes one coordinate of the matching source pixel by evaluating a bicubic polynomial. The polynomial's variables are the pixel's position relative to the rectangle's first corner, and its sixteen coefficients are set by the host. Each result goes out as a signed fixed-point value with 24 integer and 12 fractional bits. The integer part becomes the source address, and the fractional part is driven only in extended mode. The block also drives the absolute target address, one flag for a source address outside its window, one flag for a target address outside its window, and a completion flag. One instance serves one axis. A second instance with its own coefficients handles the other axis.

Each target pixel is held for k consecutive output beats, where k is the interpolation kernel size. On beat d of the dwell, the source address is offset by d, so the beats walk a small neighbourhood of source pixels. The polynomial is evaluated incrementally with cubic forward differences, so no multiplier is used. A host writes the coefficients and limits on its own clock. Each write crosses into the pixel clock domain through a toggle handshake.

Top module: `warp_seq`

## Requirements
- R1: Given uMin ≤ uMax and vMin ≤ vMax, one pass presents every target pixel exactly once, in order: tgtU runs from uMin to uMax, then tgtV increments and tgtU returns to uMin, until (uMax, vMax).
- R2: For a target pixel with u = tgtU − uMin and v = tgtV − vMin, the source coordinate is x = Σ c[i][j]·u^i·v^j for i, j in 0..3, with the coefficients read as signed 24.12 fixed point. srcAddr equals floor(x) plus the dwell index, modulo 2^24.
- R3: Each target pixel is presented on k back-to-back beats with dwell index 0..k−1. A kernel value of 0 acts as 1.
- R4: When mode bit 0 (extended) is 1, srcFrac carries the 12 fractional bits of x. When it is 0, srcFrac is 0.
- R5: srcOutWin is 1 exactly when srcAddr, read as signed, is below xLo or above xHi.
- R6: tgtOutWin is 1 exactly when tgtU is outside winULo..winUHi or tgtV is outside winVLo..winVHi.
- R7: done is 1 on the beat that carries the last dwell of (uMax, vMax). When mode bit 1 (repeat) is 0, the block then stops: outValid stays 0 and done stays 1 until the next start.
- R8: When repeat is 1, the beat of (uMin, vMin) with dwell 0 follows the last beat in the very next cycle, and done is a one-cycle pulse.
- R9: A start pulse, including one given mid-pass, clears done in the following cycle, emits no beat in that cycle, and begins a new pass at (uMin, vMin).
- R10: After reset, outValid, done and hostBusy are 0.
- R11: A host write is accepted when hostWe is 1 and hostBusy is 0. hostBusy is 1 from the next host cycle until the value is held in the pixel domain. Address map: 4·j+i holds c[i][j]; 16 uMin, 17 uMax, 18 vMin, 19 vMax, 20 winULo, 21 winUHi, 22 winVLo, 23 winVHi, 24 xLo, 25 xHi, 26 kernel k, 27 mode (bit 0 extended, bit 1 repeat). Coefficients take effect at start.
- R12: Within a pass, beats are back to back: the last beat comes (nU·nV·k − 1) cycles after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Pixel-domain asynchronous reset, active low |
| hostClk | input | 1 | Host write clock |
| hostRstN | input | 1 | Host-domain asynchronous reset, active low |
| hostWe | input | 1 | Host write request |
| hostAddr | input | 5 | Host register address |
| hostData | input | COEF_W | Host write data |
| hostBusy | output | 1 | A write is still crossing; new writes are ignored |
| start | input | 1 | Start or restart a pass |
| outValid | output | 1 | Output beat valid |
| srcAddr | output | COEF_W−FRAC_W | Integer source address plus dwell offset |
| srcFrac | output | FRAC_W | Fractional source bits (extended mode) |
| tgtU | output | TGT_W | Target horizontal address |
| tgtV | output | TGT_W | Target vertical address |
| srcOutWin | output | 1 | Source address outside xLo..xHi |
| tgtOutWin | output | 1 | Target address outside its window |
| done | output | 1 | Pass completion flag |

## Verification
The bench builds the block with 8-bit target addresses and a 3-bit kernel field, so it can set k anywhere from 0 to 7. The coefficient and fraction widths stay at their defaults, so the bench exercises the full 36-bit source coordinate. Rectangles of up to 4×3 pixels keep every beat cheap to check. Each beat is compared with a direct integer evaluation of the polynomial, which covers mixed-sign coefficients, single-pixel rectangles, wrap-around in repeat mode and a restart in mid-pass.

// File: rtl/warp_pkg.sv
package warp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic seed;      // load forward-difference seeds and rectangle origin
    logic emit;      // register an output beat this cycle
    logic stepPix;   // advance one pixel along the line
    logic stepLine;  // advance to the next line
  } warp_ctl_t;

  localparam int unsigned A_UMIN  = 16;
  localparam int unsigned A_UMAX  = 17;
  localparam int unsigned A_VMIN  = 18;
  localparam int unsigned A_VMAX  = 19;
  localparam int unsigned A_WULO  = 20;
  localparam int unsigned A_WUHI  = 21;
  localparam int unsigned A_WVLO  = 22;
  localparam int unsigned A_WVHI  = 23;
  localparam int unsigned A_XLO   = 24;
  localparam int unsigned A_XHI   = 25;
  localparam int unsigned A_KERN  = 26;
  localparam int unsigned A_MODE  = 27;
endpackage

// File: rtl/warp_regbank.sv
module warp_regbank #(
  parameter int COEF_W = 36,
  parameter int INT_W  = 24,
  parameter int TGT_W  = 16,
  parameter int KW     = 4,
  parameter int ADDR_W = 5
) (
  input  logic                         hostClk,
  input  logic                         hostRstN,
  input  logic                         hostWe,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic [COEF_W-1:0]            hostData,
  output logic                         hostBusy,
  input  logic                         clk,
  input  logic                         rstN,
  output logic [15:0][COEF_W-1:0]      coef,
  output logic [TGT_W-1:0]             uMin, uMax, vMin, vMax,
  output logic [TGT_W-1:0]             winULo, winUHi, winVLo, winVHi,
  output logic [INT_W-1:0]             xLo, xHi,
  output logic [KW-1:0]                kernel,
  output logic                         extMode,
  output logic                         repeatMode
);
  import warp_pkg::*;

  logic              reqT, ackT, ackS1, ackS2;
  logic              reqS1, reqS2, reqS3;
  logic [ADDR_W-1:0] stAddr;
  logic [COEF_W-1:0] stData;

  assign hostBusy = reqT ^ ackS2;

  // host side: stage the write and toggle the request
  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) begin
      reqT <= 1'b0; ackS1 <= 1'b0; ackS2 <= 1'b0;
      stAddr <= '0; stData <= '0;
    end else begin
      ackS1 <= ackT;
      ackS2 <= ackS1;
      if (hostWe && !hostBusy) begin
        stAddr <= hostAddr;
        stData <= hostData;
        reqT   <= ~reqT;
      end
    end
  end

  // pixel side: detect the toggle, commit, acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqS1 <= 1'b0; reqS2 <= 1'b0; reqS3 <= 1'b0; ackT <= 1'b0;
      coef <= '0;
      uMin <= '0; uMax <= '0; vMin <= '0; vMax <= '0;
      winULo <= '0; winUHi <= '0; winVLo <= '0; winVHi <= '0;
      xLo <= '0; xHi <= '0;
      kernel <= KW'(1); extMode <= 1'b0; repeatMode <= 1'b0;
    end else begin
      reqS1 <= reqT;
      reqS2 <= reqS1;
      reqS3 <= reqS2;
      ackT  <= reqS3;
      if (reqS2 ^ reqS3) begin
        if (stAddr < ADDR_W'(16)) coef[stAddr[3:0]] <= stData;
        else begin
          case (32'(stAddr))
            A_UMIN: uMin   <= stData[TGT_W-1:0];
            A_UMAX: uMax   <= stData[TGT_W-1:0];
            A_VMIN: vMin   <= stData[TGT_W-1:0];
            A_VMAX: vMax   <= stData[TGT_W-1:0];
            A_WULO: winULo <= stData[TGT_W-1:0];
            A_WUHI: winUHi <= stData[TGT_W-1:0];
            A_WVLO: winVLo <= stData[TGT_W-1:0];
            A_WVHI: winVHi <= stData[TGT_W-1:0];
            A_XLO:  xLo    <= stData[INT_W-1:0];
            A_XHI:  xHi    <= stData[INT_W-1:0];
            A_KERN: kernel <= stData[KW-1:0];
            A_MODE: begin
              extMode    <= stData[0];
              repeatMode <= stData[1];
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/warp_ctrl.sv
module warp_ctrl #(
  parameter int KW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [KW-1:0]        kernel,
  input  logic                 repeatMode,
  input  logic                 lineEnd,
  input  logic                 lastLine,
  output warp_pkg::warp_ctl_t  ctl,
  output logic [KW-1:0]        dwell,
  output logic                 done
);
  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t    state;
  logic      run, pixEnd, passEnd;
  logic [KW-1:0] kLast;

  assign run     = (state == S_RUN);
  assign kLast   = (kernel == '0) ? '0 : kernel - KW'(1);
  assign pixEnd  = (dwell == kLast);
  assign passEnd = pixEnd && lineEnd && lastLine;

  always_comb begin
    ctl          = '0;
    ctl.seed     = start || (run && passEnd && repeatMode);
    ctl.emit     = run && !start;
    ctl.stepPix  = run && !start && pixEnd && !lineEnd;
    ctl.stepLine = run && !start && pixEnd && lineEnd && !lastLine;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      dwell <= '0;
      done  <= 1'b0;
    end else if (start) begin
      state <= S_RUN;
      dwell <= '0;
      done  <= 1'b0;
    end else if (run) begin
      done <= 1'b0;
      if (pixEnd) begin
        dwell <= '0;
        if (passEnd) begin
          done <= 1'b1;
          if (!repeatMode) state <= S_IDLE;
        end
      end else begin
        dwell <= dwell + KW'(1);
      end
    end
  end
endmodule

// File: rtl/warp_datapath.sv
module warp_datapath #(
  parameter int COEF_W  = 36,
  parameter int FRAC_W  = 12,
  parameter int GUARD_W = 16,
  parameter int TGT_W   = 16,
  parameter int KW      = 4,
  localparam int ACC_W  = COEF_W + GUARD_W,
  localparam int INT_W  = COEF_W - FRAC_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  warp_pkg::warp_ctl_t     ctl,
  input  logic [KW-1:0]           dwell,
  input  logic [15:0][COEF_W-1:0] coef,
  input  logic [TGT_W-1:0]        uMin, uMax, vMin, vMax,
  input  logic [TGT_W-1:0]        winULo, winUHi, winVLo, winVHi,
  input  logic [INT_W-1:0]        xLo, xHi,
  input  logic                    extMode,
  output logic                    lineEnd,
  output logic                    lastLine,
  output logic                    outValid,
  output logic [INT_W-1:0]        srcAddr,
  output logic [FRAC_W-1:0]       srcFrac,
  output logic [TGT_W-1:0]        tgtU,
  output logic [TGT_W-1:0]        tgtV,
  output logic                    srcOutWin,
  output logic                    tgtOutWin
);
  typedef logic [3:0][ACC_W-1:0] quad_t;

  // cubic power coefficients -> value and forward differences at 0
  function automatic quad_t toDiff(quad_t a);
    quad_t r;
    r[0] = a[0];
    r[1] = a[1] + a[2] + a[3];
    r[2] = (a[2] << 1) + (a[3] << 2) + (a[3] << 1);
    r[3] = (a[3] << 2) + (a[3] << 1);
    return r;
  endfunction

  quad_t colIn [4];
  quad_t colD  [4];
  quad_t rowIn [4];
  quad_t seed  [4];
  quad_t vAcc  [4];   // vAcc[i][m]: m-th v-difference of the i-th u-difference
  quad_t pAcc;        // u-differences along the current line
  logic [TGT_W-1:0] curU, curV;
  logic [INT_W-1:0] offAddr;

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      for (int i = 0; i < 4; i++)
        colIn[j][i] = {{GUARD_W{coef[4*j+i][COEF_W-1]}}, coef[4*j+i]};
      colD[j] = toDiff(colIn[j]);
    end
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) rowIn[i][j] = colD[j][i];
      seed[i] = toDiff(rowIn[i]);
    end
  end

  assign lineEnd  = (curU == uMax);
  assign lastLine = (curV == vMax);
  assign offAddr  = pAcc[0][COEF_W-1:FRAC_W] + INT_W'(dwell);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) vAcc[i] <= '0;
      pAcc <= '0;
      curU <= '0;
      curV <= '0;
    end else if (ctl.seed) begin
      for (int i = 0; i < 4; i++) begin
        vAcc[i]  <= seed[i];
        pAcc[i]  <= seed[i][0];
      end
      curU <= uMin;
      curV <= vMin;
    end else if (ctl.stepLine) begin
      for (int i = 0; i < 4; i++) begin
        vAcc[i][0] <= vAcc[i][0] + vAcc[i][1];
        vAcc[i][1] <= vAcc[i][1] + vAcc[i][2];
        vAcc[i][2] <= vAcc[i][2] + vAcc[i][3];
        pAcc[i]    <= vAcc[i][0] + vAcc[i][1];
      end
      curU <= uMin;
      curV <= curV + TGT_W'(1);
    end else if (ctl.stepPix) begin
      pAcc[0] <= pAcc[0] + pAcc[1];
      pAcc[1] <= pAcc[1] + pAcc[2];
      pAcc[2] <= pAcc[2] + pAcc[3];
      curU    <= curU + TGT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      srcAddr   <= '0;
      srcFrac   <= '0;
      tgtU      <= '0;
      tgtV      <= '0;
      srcOutWin <= 1'b0;
      tgtOutWin <= 1'b0;
    end else begin
      outValid <= ctl.emit;
      if (ctl.emit) begin
        srcAddr   <= offAddr;
        srcFrac   <= extMode ? pAcc[0][FRAC_W-1:0] : '0;
        tgtU      <= curU;
        tgtV      <= curV;
        srcOutWin <= ($signed(offAddr) < $signed(xLo)) || ($signed(offAddr) > $signed(xHi));
        tgtOutWin <= (curU < winULo) || (curU > winUHi) || (curV < winVLo) || (curV > winVHi);
      end
    end
  end
endmodule

// File: rtl/warp_seq.sv
module warp_seq #(
  parameter int COEF_W  = 36,
  parameter int FRAC_W  = 12,
  parameter int GUARD_W = 16,
  parameter int TGT_W   = 16,
  parameter int KW      = 4,
  parameter int ADDR_W  = 5,
  localparam int INT_W  = COEF_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostClk,
  input  logic              hostRstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [COEF_W-1:0] hostData,
  output logic              hostBusy,
  input  logic              start,
  output logic              outValid,
  output logic [INT_W-1:0]  srcAddr,
  output logic [FRAC_W-1:0] srcFrac,
  output logic [TGT_W-1:0]  tgtU,
  output logic [TGT_W-1:0]  tgtV,
  output logic              srcOutWin,
  output logic              tgtOutWin,
  output logic              done
);
  warp_pkg::warp_ctl_t     ctl;
  logic [15:0][COEF_W-1:0] coef;
  logic [TGT_W-1:0]        uMin, uMax, vMin, vMax, winULo, winUHi, winVLo, winVHi;
  logic [INT_W-1:0]        xLo, xHi;
  logic [KW-1:0]           kernel, dwell;
  logic                    extMode, repeatMode, lineEnd, lastLine;

  warp_regbank #(.COEF_W(COEF_W), .INT_W(INT_W), .TGT_W(TGT_W), .KW(KW), .ADDR_W(ADDR_W)) regs_i (
    .hostClk(hostClk), .hostRstN(hostRstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostData), .hostBusy(hostBusy), .clk(clk), .rstN(rstN), .coef(coef),
    .uMin(uMin), .uMax(uMax), .vMin(vMin), .vMax(vMax),
    .winULo(winULo), .winUHi(winUHi), .winVLo(winVLo), .winVHi(winVHi),
    .xLo(xLo), .xHi(xHi), .kernel(kernel), .extMode(extMode), .repeatMode(repeatMode)
  );

  warp_ctrl #(.KW(KW)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .kernel(kernel), .repeatMode(repeatMode),
    .lineEnd(lineEnd), .lastLine(lastLine), .ctl(ctl), .dwell(dwell), .done(done)
  );

  warp_datapath #(.COEF_W(COEF_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W), .TGT_W(TGT_W), .KW(KW)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dwell(dwell), .coef(coef),
    .uMin(uMin), .uMax(uMax), .vMin(vMin), .vMax(vMax),
    .winULo(winULo), .winUHi(winUHi), .winVLo(winVLo), .winVHi(winVHi),
    .xLo(xLo), .xHi(xHi), .extMode(extMode), .lineEnd(lineEnd), .lastLine(lastLine),
    .outValid(outValid), .srcAddr(srcAddr), .srcFrac(srcFrac), .tgtU(tgtU), .tgtV(tgtV),
    .srcOutWin(srcOutWin), .tgtOutWin(tgtOutWin)
  );
endmodule

// File: rtl/warp_seq_chk.sv
module warp_seq_chk #(
  parameter int TGT_W  = 16,
  parameter int KW     = 4,
  parameter int INT_W  = 24,
  parameter int FRAC_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostClk,
  input logic              hostRstN,
  input logic              hostWe,
  input logic              hostBusy,
  input logic              start,
  input logic              outValid,
  input logic              done,
  input logic [TGT_W-1:0]  tgtU,
  input logic [TGT_W-1:0]  tgtV,
  input logic [INT_W-1:0]  srcAddr,
  input logic [FRAC_W-1:0] srcFrac,
  input logic              extMode,
  input logic [KW-1:0]     dwell
);
  // R3: inside a dwell the target holds and the source steps by one
  p_dwell_walk_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && $past(dwell) != '0) |->
      ($stable(tgtU) && $stable(tgtV) && srcAddr == $past(srcAddr) + INT_W'(1)));

  // R4: fraction is zero outside extended mode
  p_frac_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(extMode)) |-> (srcFrac == '0));

  // R7: done only rises together with a beat
  p_done_with_beat_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> outValid);

  // R7: halted completion holds until start
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !outValid && !start) |=> (done && !outValid));

  // R9: start clears done and emits nothing in the following cycle
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(start) |-> (!done && !outValid));

  // R11: an accepted write raises busy on the next host cycle
  p_busy_after_write_r11: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (hostWe && !hostBusy) |=> hostBusy);
endmodule

bind warp_seq warp_seq_chk #(.TGT_W(TGT_W), .KW(KW), .INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rstN(rstN), .hostClk(hostClk), .hostRstN(hostRstN), .hostWe(hostWe),
  .hostBusy(hostBusy), .start(start), .outValid(outValid), .done(done), .tgtU(tgtU),
  .tgtV(tgtV), .srcAddr(srcAddr), .srcFrac(srcFrac), .extMode(extMode), .dwell(dwell)
);

// File: tb/warp_seq_tb_top.sv
module warp_seq_tb_top;
  localparam int COEF_W = 36;
  localparam int FRAC_W = 12;
  localparam int TGT_W  = 8;
  localparam int KW     = 3;
  localparam int INT_W  = COEF_W - FRAC_W;

  logic clk = 0, hostClk = 0, rstN = 0, hostRstN = 0;
  logic hostWe = 0, start = 0;
  logic [4:0] hostAddr = '0;
  logic [COEF_W-1:0] hostData = '0;
  logic hostBusy, outValid, srcOutWin, tgtOutWin, done;
  logic [INT_W-1:0] srcAddr;
  logic [FRAC_W-1:0] srcFrac;
  logic [TGT_W-1:0] tgtU, tgtV;

  always #5 clk = ~clk;
  always #7 hostClk = ~hostClk;

  warp_seq #(.COEF_W(COEF_W), .FRAC_W(FRAC_W), .TGT_W(TGT_W), .KW(KW)) dut_i (
    .clk(clk), .rstN(rstN), .hostClk(hostClk), .hostRstN(hostRstN), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostData(hostData), .hostBusy(hostBusy), .start(start),
    .outValid(outValid), .srcAddr(srcAddr), .srcFrac(srcFrac), .tgtU(tgtU), .tgtV(tgtV),
    .srcOutWin(srcOutWin), .tgtOutWin(tgtOutWin), .done(done)
  );

  int nRun = 0, nFail = 0;
  longint cf [16];
  int uMn, uMx, vMn, vMx, wUl, wUh, wVl, wVh, kk, ext, rep;
  longint xl, xh;
  int expU, expV, expD, passes = 0, beatsInPass = 0;
  longint cyc = 0, firstCyc = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint pw(int b, int e);
    longint r = 1;
    for (int n = 0; n < e; n++) r = r * b;
    return r;
  endfunction

  function automatic longint cfVal(int s, int k);
    return longint'(((k * 7919 + s * 131) % 2001) - 1000) * 1000 + longint'(k * 17);
  endfunction

  // reference model: checks every beat
  always @(negedge clk) begin
    longint x, ip, ad, sa;
    int u, v, kEff;
    bit last, sOut, tOut;
    cyc++;
    if (rstN && outValid) begin
      kEff = (kk == 0) ? 1 : kk;
      u = expU - uMn; v = expV - vMn;
      x = 0;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) x += cf[4*j+i] * pw(u, i) * pw(v, j);
      ip = x >>> FRAC_W;
      ad = (ip + expD) & ((longint'(1) << INT_W) - 1);
      sa = (ad >= (longint'(1) << (INT_W-1))) ? ad - (longint'(1) << INT_W) : ad;
      sOut = (sa < xl) || (sa > xh);
      tOut = (expU < wUl) || (expU > wUh) || (expV < wVl) || (expV > wVh);
      if (expU == uMn && expV == vMn && expD == 0) begin firstCyc = cyc; beatsInPass = 0; end
      beatsInPass++;
      last = (expU == uMx) && (expV == vMx) && (expD == kEff - 1);
      chk(tgtU == TGT_W'(expU), "R1 tgtU", tgtU, expU);
      chk(tgtV == TGT_W'(expV), "R1 tgtV", tgtV, expV);
      chk(srcAddr == INT_W'(ad), "R2/R3 srcAddr", srcAddr, ad);
      chk(srcFrac == (ext ? FRAC_W'(x) : '0), "R4 srcFrac", srcFrac, ext ? (x & 12'hFFF) : 0);
      chk(srcOutWin == sOut, "R5 srcOutWin", srcOutWin, sOut);
      chk(tgtOutWin == tOut, "R6 tgtOutWin", tgtOutWin, tOut);
      chk(done == last, "R7 done on last beat", done, last);
      if (last) begin
        chk(cyc - firstCyc + 1 == longint'((uMx-uMn+1)*(vMx-vMn+1)*kEff), "R12 back-to-back",
            cyc - firstCyc + 1, (uMx-uMn+1)*(vMx-vMn+1)*kEff);
        chk(beatsInPass == (uMx-uMn+1)*(vMx-vMn+1)*kEff, "R1 beat count", beatsInPass,
            (uMx-uMn+1)*(vMx-vMn+1)*kEff);
        passes++;
      end
      if (expD == kEff - 1) begin
        expD = 0;
        if (expU == uMx) begin
          expU = uMn;
          expV = (expV == vMx) ? vMn : expV + 1;
        end else expU++;
      end else expD++;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  task automatic hostWrite(int a, longint d);
    @(negedge hostClk);
    while (hostBusy) @(negedge hostClk);
    hostWe = 1; hostAddr = 5'(a); hostData = COEF_W'(d);
    @(negedge hostClk);
    hostWe = 0;
    chk(hostBusy == 1'b1, "R11 busy after accept", hostBusy, 1);
    while (hostBusy) @(negedge hostClk);
  endtask

  task automatic loadAll(int s);
    for (int k = 0; k < 16; k++) begin
      cf[k] = cfVal(s, k);
      hostWrite(k, cf[k]);
    end
    hostWrite(16, uMn); hostWrite(17, uMx); hostWrite(18, vMn); hostWrite(19, vMx);
    hostWrite(20, wUl); hostWrite(21, wUh); hostWrite(22, wVl); hostWrite(23, wVh);
    hostWrite(24, xl);  hostWrite(25, xh);  hostWrite(26, kk);
    hostWrite(27, ext | (rep << 1));
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    expU = uMn; expV = vMn; expD = 0;
    chk(done == 1'b0 && outValid == 1'b0, "R9 start clears done, no beat", done, 0);
  endtask

  task automatic waitHalt();
    @(negedge clk);
    while (!(done && !outValid)) @(negedge clk);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk(done == 1'b1 && outValid == 1'b0, "R7 halted after pass", {done, outValid}, 2);
    end
  endtask

  initial begin
    int p;
    uMn = 0; uMx = 0; vMn = 0; vMx = 0; kk = 1; ext = 0; rep = 0;
    wUl = 0; wUh = 0; wVl = 0; wVh = 0; xl = 0; xh = 0;
    expU = 0; expV = 0; expD = 0;
    repeat (3) @(negedge clk);
    rstN = 1; hostRstN = 1;
    @(negedge clk);
    chk(outValid == 0, "R10 outValid after reset", outValid, 0);
    chk(done == 0, "R10 done after reset", done, 0);
    chk(hostBusy == 0, "R10 hostBusy after reset", hostBusy, 0);

    // halt mode, k=2, extended, mixed windows
    uMn = 3; uMx = 6; vMn = 10; vMx = 12; kk = 2; ext = 1; rep = 0;
    wUl = 4; wUh = 5; wVl = 10; wVh = 11; xl = -3000; xh = 3000;
    loadAll(1);
    pulseStart(); waitHalt();

    // restart mid-pass (R9)
    pulseStart();
    repeat (7) @(negedge clk);
    pulseStart(); waitHalt();

    // single pixel, k=3, fraction off
    uMn = 7; uMx = 7; vMn = 200; vMx = 200; kk = 3; ext = 0; rep = 0;
    wUl = 0; wUh = 6; wVl = 0; wVh = 255; xl = -100000; xh = 100000;
    loadAll(2);
    pulseStart(); waitHalt();

    // k=0 acts as 1, maximum dwell 7 separately; repeat mode
    uMn = 0; uMx = 3; vMn = 0; vMx = 2; kk = 0; ext = 1; rep = 1;
    wUl = 1; wUh = 2; wVl = 1; wVh = 1; xl = -20000; xh = 500;
    loadAll(3);
    pulseStart();
    p = passes;
    wait (passes == p + 1);
    @(negedge clk);
    chk(outValid == 1'b1 && done == 1'b0, "R8 wrap next cycle, done pulse", {outValid, done}, 2);
    chk(tgtU == TGT_W'(uMn) && tgtV == TGT_W'(vMn), "R8 wrap to origin", tgtU, uMn);
    wait (passes == p + 2);
    rep = 0;
    hostWrite(27, ext);
    waitHalt();

    kk = 7; rep = 0; ext = 0;
    hostWrite(26, kk); hostWrite(27, 0);
    pulseStart(); waitHalt();

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule